// File: doc/BRIEF.md
# Bit-Slice Slave Configuration Sequencer

This block runs in a master device that is already configured. From a byte-wide memory it loads up to eight further slave devices. Each memory word carries one bit for each slave, and bit n goes to the serial data pin of slave n. The block generates the memory address from the configuration clock. That clock is the same one the slaves receive as their serial clock. The address starts at an offset base, above the region that holds the master's own image. The block drives the memory chip select and the start line, which feeds the slaves' active-low configure inputs. It also watches the wired done line that all slaves share.

After reset, the start line is held low for a set number of clocks so that the slaves are cleared. The line then rises and stays high. One clock later, the chip select asserts and the address begins to advance by one per clock. When the shared done line is seen high, the following things happen:

- counting stops;
- the memory is deselected;
- the address pins switch over to an address supplied by user logic;
- the start line is kept high until the next reset.

The slice region may be used up before done arrives. In that case counting stops at the last address and a sticky error flag is raised.

Top module: `cfg_slice_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `slave_cfg_start` is 0, `mem_cs_n` is 1, `mem_addr` equals BASE, `pins_released` is 0 and `slice_overrun` is 0.
- R2: After reset is released, `slave_cfg_start` stays 0 for exactly START_LOW clock cycles. It then goes to 1.
- R3: `mem_cs_n` goes low one cycle after `slave_cfg_start` rises, with `mem_addr` = BASE. The address then rises by exactly one on each clock while counting.
- R4: While `mem_cs_n` is low, `slave_data[n]` equals `mem_rdata[n]` for each slave n. At all other times `slave_data` is all zeros.
- R5: If `slaves_done` is high at a clock edge while counting, from that edge on: counting stops, `pins_released` is 1, `mem_addr` follows `user_addr`, and `mem_cs_n` is 1.
- R6: Once released, `pins_released` and `slave_cfg_start` both stay at 1 until reset, even if `slaves_done` later falls.
- R7: `slaves_done` has no effect while the start line is low, or in the cycle in which counting begins. Counting then starts at BASE as normal.
- R8: If the address reaches BASE+SLICE_LEN-1 and `slaves_done` is still low, the following happen:
  - on the next edge, `mem_cs_n` goes to 1;
  - `mem_addr` holds that last address;
  - `slice_overrun` becomes 1 and stays 1 until reset.

  If `slaves_done` rises later, the pins are still released.
- R9: A reset applied in any phase returns the block to the R1 state and starts the R2 start sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; the same net is used as the slaves' serial clock |
| rst | input | 1 | Synchronous active-high reset |
| slaves_done | input | 1 | Shared done line of all slaves; high means all slaves are configured |
| user_addr | input | ADDR_W | Address driven by user logic after release |
| mem_rdata | input | DATA_W | Data word read from the configuration memory |
| mem_addr | output | ADDR_W | Memory address while counting; user address after release |
| mem_cs_n | output | 1 | Active-low memory chip select |
| slave_cfg_start | output | 1 | Start line to the slaves' active-low configure inputs |
| slave_data | output | NUM_SLAVES | Serial data, one bit per slave |
| pins_released | output | 1 | High once the address pins belong to user logic |
| slice_overrun | output | 1 | Sticky flag: the slice region was used up before done |

## Verification
The bench builds the block with BASE = 16, SLICE_LEN = 10, START_LOW = 3 and NUM_SLAVES = 3, and keeps a 20-bit address. With these values the whole slice window is ten clocks long. This makes the overrun boundary at address 25 reachable, including the cycle just before it, and the sticky behaviour after it. It also allows a done arriving after an overrun to be tried. Using three slaves on an 8-bit memory word shows that only the low data bits are fanned out. The short start window allows a done that arrives too early to be placed on every cycle of the arming phase.

// File: rtl/cfg_slice_pkg.sv
package cfg_slice_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2,
    SEQ_OVR  = 2'd3
  } seq_phase_t;
endpackage

// File: rtl/cfg_start_gen.sv
module cfg_start_gen #(
  parameter int START_LOW = 4
) (
  input  logic clk,
  input  logic rst,
  output logic armed
);
  localparam int CW = $clog2(START_LOW + 1);
  localparam logic [CW-1:0] LAST_ARM = CW'(START_LOW - 1);

  logic [CW-1:0] arm_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_cnt <= '0;
      armed   <= 1'b0;
    end else if (!armed) begin
      if (arm_cnt == LAST_ARM) armed <= 1'b1;
      else                     arm_cnt <= arm_cnt + 1'b1;
    end
  end

  // R6: once high, the start line never drops again without a reset
  a_r6_start_latched: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);

  // R2: the hold counter stays inside the low window
  a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (arm_cnt <= LAST_ARM));
endmodule

// File: rtl/cfg_addr_seq.sv
module cfg_addr_seq
  import cfg_slice_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BASE      = 32768,
  parameter int SLICE_LEN = 196608
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armed,
  input  logic              done,
  output logic [ADDR_W-1:0] cnt,
  output seq_phase_t        phase,
  output logic              overrun
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE + SLICE_LEN - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= SEQ_IDLE;
      cnt     <= BASE_A;
      overrun <= 1'b0;
    end else begin
      unique case (phase)
        SEQ_IDLE: if (armed) phase <= SEQ_RUN;
        SEQ_RUN: begin
          if (done) begin
            phase <= SEQ_DONE;
          end else if (cnt == LAST_A) begin
            phase   <= SEQ_OVR;
            overrun <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_OVR:  if (done) phase <= SEQ_DONE;
        SEQ_DONE: phase <= SEQ_DONE;
        default:  phase <= SEQ_IDLE;
      endcase
    end
  end

  // R3: two running cycles in a row mean exactly one address step
  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    (phase == SEQ_RUN && $past(phase) == SEQ_RUN) |-> (cnt == $past(cnt) + 1'b1));

  // R5: a stopped counter never moves again
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    (phase == SEQ_DONE) |=> (phase == SEQ_DONE && $stable(cnt)));

  // R8: the address never leaves the slice window
  a_r8_in_window: assert property (@(posedge clk) disable iff (rst)
    (cnt >= BASE_A) && (cnt <= LAST_A));

  // R8: the error flag is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

// File: rtl/cfg_pin_mux.sv
module cfg_pin_mux
  import cfg_slice_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 8,
  parameter int NUM_SLAVES = 8
) (
  input  seq_phase_t            phase,
  input  logic [ADDR_W-1:0]     cnt,
  input  logic [ADDR_W-1:0]     user_addr,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_cs_n,
  output logic [NUM_SLAVES-1:0] slave_data,
  output logic                  released
);
  logic running;

  assign running  = (phase == SEQ_RUN);
  assign released = (phase == SEQ_DONE);
  assign mem_cs_n = !running;
  assign mem_addr = released ? user_addr : cnt;

  for (genvar n = 0; n < NUM_SLAVES; n++) begin : g_slave
    assign slave_data[n] = running & mem_rdata[n];
  end
endmodule

// File: rtl/cfg_slice_seq.sv
module cfg_slice_seq
  import cfg_slice_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 8,
  parameter int NUM_SLAVES = 8,
  parameter int BASE       = 32768,
  parameter int SLICE_LEN  = 196608,
  parameter int START_LOW  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  slaves_done,
  input  logic [ADDR_W-1:0]     user_addr,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_cs_n,
  output logic                  slave_cfg_start,
  output logic [NUM_SLAVES-1:0] slave_data,
  output logic                  pins_released,
  output logic                  slice_overrun
);
  logic              armed;
  logic [ADDR_W-1:0] cnt;
  seq_phase_t        phase;

  cfg_start_gen #(.START_LOW(START_LOW)) u_start (
    .clk   (clk),
    .rst   (rst),
    .armed (armed)
  );

  cfg_addr_seq #(.ADDR_W(ADDR_W), .BASE(BASE), .SLICE_LEN(SLICE_LEN)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .armed   (armed),
    .done    (slaves_done),
    .cnt     (cnt),
    .phase   (phase),
    .overrun (slice_overrun)
  );

  cfg_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLAVES(NUM_SLAVES)) u_mux (
    .phase      (phase),
    .cnt        (cnt),
    .user_addr  (user_addr),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .slave_data (slave_data),
    .released   (pins_released)
  );

  assign slave_cfg_start = armed;

  // R3: the memory is only selected once the start line is high
  a_r3_cs_after_start: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> slave_cfg_start);

  // R5: released pins imply a deselected memory
  a_r5_release_cs: assert property (@(posedge clk) disable iff (rst)
    pins_released |-> (mem_cs_n && slave_cfg_start));

  // R6: release is permanent until reset
  a_r6_release_hold: assert property (@(posedge clk) disable iff (rst)
    pins_released |=> pins_released);
endmodule

// File: tb/cfg_slice_seq_bench.sv
`timescale 1ns/1ps
module cfg_slice_seq_bench;
  localparam int ADDR_W = 20, DATA_W = 8, NS = 3, BASE = 16, LEN = 10, SLOW = 3;
  localparam int LAST = BASE + LEN - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done = 1'b0;
  logic [ADDR_W-1:0] user_addr = 20'hABCDE;
  logic [DATA_W-1:0] mem_rdata;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_cs_n, start, released, ovr;
  logic [NS-1:0] sdata;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  always_comb mem_rdata = mem_addr[7:0] ^ 8'h5A;

  cfg_slice_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SLAVES(NS), .BASE(BASE),
                  .SLICE_LEN(LEN), .START_LOW(SLOW)) u_cfg_slice_seq (
    .clk(clk), .rst(rst), .slaves_done(done), .user_addr(user_addr),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .slave_cfg_start(start), .slave_data(sdata), .pins_released(released),
    .slice_overrun(ovr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [NS-1:0] exp_data(input logic [ADDR_W-1:0] a);
    logic [7:0] w;
    w = a[7:0] ^ 8'h5A;
    return w[NS-1:0];
  endfunction

  task automatic do_reset();
    rst = 1'b1; done = 1'b0;
    step(); step();
    chk("R1 start", start, 0);
    chk("R1 cs_n", mem_cs_n, 1);
    chk("R1 addr", mem_addr, BASE);
    chk("R1 released", released, 0);
    chk("R1 overrun", ovr, 0);
    chk("R4 idle data", sdata, 0);
    rst = 1'b0;
  endtask

  // R2/R3: start window, then first address
  task automatic t_arm();
    for (int i = 1; i <= SLOW; i++) begin
      step();
      chk("R2 start", start, (i == SLOW) ? 1 : 0);
      chk("R3 cs_n before run", mem_cs_n, 1);
    end
    step();
    chk("R3 cs asserted", mem_cs_n, 0);
    chk("R3 first addr", mem_addr, BASE);
    chk("R4 data", sdata, exp_data(BASE));
  endtask

  // R3/R4/R5/R6: count, then done stops and releases
  task automatic t_done();
    do_reset();
    t_arm();
    for (int j = 1; j <= 3; j++) begin
      step();
      chk("R3 addr step", mem_addr, BASE + j);
      chk("R4 data", sdata, exp_data(ADDR_W'(BASE + j)));
    end
    done = 1'b1;
    step();
    chk("R5 released", released, 1);
    chk("R5 user addr", mem_addr, user_addr);
    chk("R5 cs_n", mem_cs_n, 1);
    chk("R4 data after done", sdata, 0);
    done = 1'b0;
    step(); step();
    chk("R6 release held", released, 1);
    chk("R6 start held", start, 1);
    user_addr = 20'h01234;
    #1;
    chk("R5 addr follows user", mem_addr, 20'h01234);
  endtask

  // R7: done during arming is ignored
  task automatic t_early_done();
    do_reset();
    done = 1'b1;
    for (int i = 1; i <= SLOW + 1; i++) step();
    chk("R7 not released", released, 0);
    chk("R7 counting", mem_cs_n, 0);
    chk("R7 base", mem_addr, BASE);
    done = 1'b0;
    step();
    chk("R7 advances", mem_addr, BASE + 1);
  endtask

  // R8/R9: exhaust the window, then done, then reset
  task automatic t_overrun();
    do_reset();
    t_arm();
    for (int j = 1; j <= LEN - 1; j++) step();
    chk("R8 last addr", mem_addr, LAST);
    chk("R8 no flag yet", ovr, 0);
    chk("R8 cs at last", mem_cs_n, 0);
    step();
    chk("R8 flag", ovr, 1);
    chk("R8 cs_n", mem_cs_n, 1);
    chk("R8 hold addr", mem_addr, LAST);
    step(); step();
    chk("R8 sticky", ovr, 1);
    chk("R8 still held", mem_addr, LAST);
    done = 1'b1;
    step();
    chk("R8 release after overrun", released, 1);
    chk("R8 flag kept", ovr, 1);
    done = 1'b0;
    rst = 1'b1;
    step();
    chk("R9 start low", start, 0);
    chk("R9 addr base", mem_addr, BASE);
    chk("R9 flag cleared", ovr, 0);
    chk("R9 not released", released, 0);
    rst = 1'b0;
    t_arm();
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_done();
    t_early_done();
    t_overrun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule